// File: doc/BRIEF.md
# Cascadable Presettable Up/Down Counter

A fully synchronous binary counter, four bits wide by default, that can count up, count down, hold, or take a parallel preset. Every change of state happens on the rising clock edge. Two active-low enables must both be low for a count step. One enable gates counting only. The other, the chain enable, also qualifies the terminal-count decode. A direction input chooses between incrementing and decrementing.

The active-low terminal-count output flags the last value before a wrap in the selected direction: all ones when counting up, zero when counting down. It is qualified only by the chain enable. Wider counters are built by feeding each stage's terminal-count output into the next stage's chain enable. All stages share the clock, the preset control, the count enable and the direction. The combined value then steps by exactly one per enabled clock, with no ripple through the clock path. An asynchronous active-low reset clears the count; its release is synchronised to the clock.

Top module: `bidir_preset_counter`

## Requirements
- R1: While reset is asserted, and after its release, the count is 0 until the first operation that changes it.
- R2: When `load_n` is 0 at a rising edge, `q` takes `din` after that edge. This holds whatever the levels of `cnt_en_n`, `chain_en_n` and `up_dn`.
- R3: When `load_n` is 1, `cnt_en_n` is 0, `chain_en_n` is 0 and `up_dn` is 1, `q` increments by one per edge. The all-ones value wraps to 0.
- R4: With the same enables and `up_dn` set to 0, `q` decrements by one per edge. The value 0 wraps to all ones.
- R5: When `load_n` is 1 and either `cnt_en_n` or `chain_en_n` is 1, `q` keeps its value.
- R6: `term_n` is 0 exactly when `chain_en_n` is 0 and either `up_dn` is 1 with `q` all ones, or `up_dn` is 0 with `q` 0. Otherwise it is 1. It follows changes of `up_dn` and `chain_en_n` without waiting for a clock edge.
- R7: `term_n` does not depend on `cnt_en_n`.
- R8: Stages chained through `term_n` into the next stage's `chain_en_n`, with shared controls, form a wider counter. It steps by exactly one per enabled clock in both directions and wraps at its full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_n | input | 1 | Active-low parallel preset; has priority over everything else |
| cnt_en_n | input | 1 | Active-low count enable; has no effect on the terminal-count output |
| chain_en_n | input | 1 | Active-low chain enable; gates both counting and the terminal-count output |
| up_dn | input | 1 | Direction select: 1 counts up, 0 counts down |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Current count |
| term_n | output | 1 | Active-low terminal count |

## Verification
The clocked properties assume that the controls and `din` are stable across each rising edge. They also assume that reset is released only while `load_n`, `cnt_en_n` and `chain_en_n` are all high, so the synchroniser window adds no unseen step. The stimulus changes every input on the falling edge and holds all three controls inactive for several cycles around each reset release. `term_n` is sampled right after each input change, and the count is sampled half a period after the edge that updates it.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } bpc_op_e;
endpackage

// File: rtl/bpc_rst_sync.sv
module bpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ok = sync_q[STAGES-1];
endmodule

// File: rtl/bpc_next.sv
module bpc_next
  import bpc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             load_n,
  input  logic             cnt_en_n,
  input  logic             chain_en_n,
  input  logic             up_dn,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_nxt,
  output logic             upd_en
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  bpc_op_e op;

  always_comb begin
    if (!load_n)                   op = OP_LOAD;
    else if (cnt_en_n | chain_en_n) op = OP_HOLD;
    else if (up_dn)                op = OP_INC;
    else                           op = OP_DEC;
  end

  always_comb begin
    unique case (op)
      OP_LOAD: q_nxt = din;
      OP_INC:  q_nxt = q + ONE;
      OP_DEC:  q_nxt = q - ONE;
      default: q_nxt = q;
    endcase
  end

  assign upd_en = (op != OP_HOLD);
endmodule

// File: rtl/bpc_state_reg.sv
module bpc_state_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_ok,
  input  logic             upd_en,
  input  logic [WIDTH-1:0] q_nxt,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)     q <= '0;
    else if (upd_en) q <= q_nxt;
  end
endmodule

// File: rtl/bpc_term_decode.sv
module bpc_term_decode #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             up_dn,
  input  logic             chain_en_n,
  output logic             term_n
);
  logic [WIDTH:0] ones_chain;
  logic [WIDTH:0] zero_chain;

  assign ones_chain[0] = 1'b1;
  assign zero_chain[0] = 1'b1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign ones_chain[b+1] = ones_chain[b] &  q[b];
    assign zero_chain[b+1] = zero_chain[b] & ~q[b];
  end

  logic at_end;
  assign at_end = up_dn ? ones_chain[WIDTH] : zero_chain[WIDTH];
  assign term_n = ~(at_end & ~chain_en_n);
endmodule

// File: rtl/bidir_preset_counter.sv
module bidir_preset_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             cnt_en_n,
  input  logic             chain_en_n,
  input  logic             up_dn,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             term_n
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic             rst_ok;
  logic [WIDTH-1:0] q_nxt;
  logic             upd_en;

  bpc_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_ok(rst_ok)
  );

  bpc_next #(.WIDTH(WIDTH)) u_next (
    .load_n(load_n), .cnt_en_n(cnt_en_n), .chain_en_n(chain_en_n),
    .up_dn(up_dn), .din(din), .q(q), .q_nxt(q_nxt), .upd_en(upd_en)
  );

  bpc_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk), .rst_ok(rst_ok), .upd_en(upd_en), .q_nxt(q_nxt), .q(q)
  );

  bpc_term_decode #(.WIDTH(WIDTH)) u_term (
    .q(q), .up_dn(up_dn), .chain_en_n(chain_en_n), .term_n(term_n)
  );

  // R2
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !load_n |=> q == $past(din));

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (load_n && !cnt_en_n && !chain_en_n && up_dn) |=> q == $past(q) + ONE);

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (load_n && !cnt_en_n && !chain_en_n && !up_dn) |=> q == $past(q) - ONE);

  // R5
  hold_val_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (load_n && (cnt_en_n || chain_en_n)) |=> $stable(q));

  // R6
  term_gate_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !term_n |-> (!chain_en_n && (q == '1 || q == '0)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_ok |-> q == '0);
endmodule

// File: tb/bpc_cascade.sv
module bpc_cascade #(
  parameter int STAGES = 3,
  parameter int WIDTH  = 4,
  localparam int TOTAL = STAGES * WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_n,
  input  logic             cnt_en_n,
  input  logic             chain_en_n,
  input  logic             up_dn,
  input  logic [TOTAL-1:0] din,
  output logic [TOTAL-1:0] q,
  output logic             term_n
);
  logic [STAGES:0] link_n;
  assign link_n[0] = chain_en_n;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    bidir_preset_counter #(.WIDTH(WIDTH)) u_stage (
      .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_n(cnt_en_n),
      .chain_en_n(link_n[s]), .up_dn(up_dn),
      .din(din[s*WIDTH +: WIDTH]), .q(q[s*WIDTH +: WIDTH]),
      .term_n(link_n[s+1])
    );
  end

  assign term_n = link_n[STAGES];
endmodule

// File: tb/bidir_preset_counter_tb_top.sv
module bidir_preset_counter_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, load_n, cnt_en_n, chain_en_n, up_dn;
  logic [3:0]  din, q;
  logic        term_n;
  logic [11:0] c_q;
  logic        c_term_n;

  int checks = 0;
  int fails  = 0;
  int m_q    = 0;
  int m_c    = 0;
  bit done   = 0;

  bidir_preset_counter #(.WIDTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_n(cnt_en_n),
    .chain_en_n(chain_en_n), .up_dn(up_dn), .din(din), .q(q), .term_n(term_n)
  );

  bpc_cascade #(.STAGES(3), .WIDTH(4)) chain_i (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .cnt_en_n(cnt_en_n),
    .chain_en_n(chain_en_n), .up_dn(up_dn), .din({3{din}}), .q(c_q),
    .term_n(c_term_n)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int next_val(int cur, int d, int span);
    if (!load_n) return d;
    if (cnt_en_n || chain_en_n) return cur;
    if (up_dn) return (cur + 1) % span;
    return (cur + span - 1) % span;
  endfunction

  task automatic step(bit ld, bit ce, bit ch, bit up, int d);
    string tq;
    load_n = ld; cnt_en_n = ce; chain_en_n = ch; up_dn = up; din = 4'(d);
    #1;
    check(ce ? "R7" : "R6", int'(term_n),
          (!ch && ((up && m_q == 15) || (!up && m_q == 0))) ? 0 : 1);
    if (!ld) tq = "R2";
    else if (ce || ch) tq = "R5";
    else if (up) tq = "R3";
    else tq = "R4";
    @(posedge clk);
    m_q = next_val(m_q, d, 16);
    m_c = next_val(m_c, d * 273, 4096);
    @(negedge clk);
    check(tq, int'(q), m_q);
    check("R8", int'(c_q), m_c);
  endtask

  task automatic do_reset();
    load_n = 1; cnt_en_n = 1; chain_en_n = 1; up_dn = 1; din = 0;
    rst_n = 0;
    m_q = 0; m_c = 0;
    repeat (2) @(negedge clk);
    check("R1", int'(q), 0);
    check("R1", int'(c_q), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1", int'(q), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    @(negedge clk);
    do_reset();
    // R2: load ignores enables and direction
    step(0, 0, 0, 0, 5);
    step(0, 1, 1, 1, 9);
    // R3: count up through wrap
    for (int i = 0; i < 8; i++) step(1, 0, 0, 1, 0);
    // R6 / R7 at all-ones in up mode, direction flip
    step(0, 1, 1, 1, 15);
    step(1, 1, 0, 1, 0);
    step(1, 0, 1, 1, 0);
    step(1, 1, 0, 0, 0);
    // R5: hold with each enable high
    step(1, 1, 0, 1, 3);
    step(1, 0, 1, 0, 3);
    // R4: count down through wrap
    step(0, 0, 0, 1, 2);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 0);
    // R6 at zero, then flip to up
    step(0, 1, 1, 0, 0);
    step(1, 1, 0, 0, 0);
    step(1, 1, 0, 1, 0);
    step(1, 0, 0, 0, 0);
    // R8: wide wrap both ways
    step(0, 0, 0, 1, 15);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1, 0);
    for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0);
    step(0, 1, 1, 1, 0);
    for (int i = 0; i < 20; i++) step(1, 0, 0, 1, 0);
    for (int i = 0; i < 25; i++) step(1, 0, 0, 0, 0);
    // R1: mid-run reset
    step(0, 1, 1, 1, 7);
    do_reset();
    step(1, 0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule